// File: doc/BRIEF.md
# Per-Instruction Miss Profiler and Latency Labeler

This block watches a stream of memory references. Each reference carries the index of the static load/store instruction that made it, plus two flags that an external cache model has already worked out. The first flag says whether the line had been evicted before this access. The second says whether the line will be evicted before its next use. From these two flags the block gives each reference one of four annotations and keeps a running total for each annotation kind. For each instruction slot it also keeps a saturating reference counter and a saturating miss counter.

On request, a labeling pass walks the slots one per cycle. It labels a slot long-latency (a prefetch candidate) when that slot's miss ratio is strictly above a programmable 8-bit fractional threshold. The comparison uses cross-multiplication instead of a divider. The same pass sums two figures for the program as labeled: the misses left over in short-latency slots, and the references that would be prefetched from long-latency slots. A clear input empties all of this state.

Top module: `miss_profiler`

## Requirements
- R1: One cycle after a reference is accepted, `ann_valid` is 1 and `ann_code` carries the annotation, decoded from {`ref_was_repl`, `ref_will_repl`} as follows: {0,0} gives 0 (do nothing), {1,0} gives 1 (pretouch), {1,1} gives 2 (prefetch), {0,1} gives 3 (replace). `ann_valid` is 0 in any cycle that follows no accepted reference.
- R2: Each accepted reference adds one to the reference counter of slot `ref_idx`. It also adds one to that slot's miss counter when `ref_was_repl` is 1.
- R3: Both per-slot counters saturate at 2**CNT_W-1 and stay there as further references arrive.
- R4: A labeling pass sets `lbl_long[i]` to 1 exactly when misses_i*256 > threshold*refs_i, with `threshold` read as an unsigned fraction of 256 and captured when the pass starts. A slot with no references is always labeled 0.
- R5: A `label_start` seen while idle raises `label_busy` on the next edge. The pass then handles one slot per cycle, so `label_done` pulses for exactly one cycle, SLOTS edges after the start edge, and `label_busy` falls at the same time. A `label_start` seen during a pass has no effect.
- R6: When `label_done` pulses, `residual_misses` equals the sum of miss counters over slots labeled 0, and `prefetch_refs` equals the sum of reference counters over slots labeled 1.
- R7: `tot_nothing`, `tot_pretouch`, `tot_prefetch` and `tot_replace` each count the accepted references that received that annotation.
- R8: `clr` zeroes all per-slot counters, the annotation totals, `lbl_long`, `residual_misses` and `prefetch_refs`, and aborts any pass in progress. A reference presented in the same cycle as `clr` is dropped and sets no `ann_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all profile state |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_idx | input | IDX_W | Static instruction slot of the reference |
| ref_was_repl | input | 1 | Line was evicted before this access (a miss) |
| ref_will_repl | input | 1 | Line will be evicted before its next use |
| ann_valid | output | 1 | Annotation output is valid |
| ann_code | output | 2 | Annotation of the previous reference |
| threshold | input | 8 | Miss-ratio threshold as a fraction of 256 |
| label_start | input | 1 | Begin a labeling pass |
| label_busy | output | 1 | Labeling pass in progress |
| label_done | output | 1 | One-cycle pulse at the end of a pass |
| lbl_long | output | SLOTS | Per-slot long-latency label |
| residual_misses | output | ACC_W | Misses of short-latency slots |
| prefetch_refs | output | ACC_W | References of long-latency slots |
| tot_nothing | output | TOT_W | Count of do-nothing annotations |
| tot_pretouch | output | TOT_W | Count of pretouch annotations |
| tot_prefetch | output | TOT_W | Count of prefetch annotations |
| tot_replace | output | TOT_W | Count of replace annotations |

## Verification
The bench drives every flag combination into every slot of a reduced configuration, so a swapped annotation code, or a miss counted on the wrong flag, shows up in the per-reference codes and in the totals. It runs labeling passes at thresholds of 0, mid-range and 255, and on slots whose miss count equals their reference count. An off-by-one or inverted comparison labels those slots wrongly and skews the residual and prefetch sums. It drives more references into two slots than the counters can hold: a counter that wraps instead of saturating sharply lowers that slot's ratio and the prefetch sum. It also retriggers a pass mid-scan and clears both while a reference arrives and while a pass is running, which catches a restarted scan (late done pulse), a dropped abort, or a stray count.

// File: rtl/miss_profiler.sv
module miss_profiler #(
  parameter int SLOTS = 64,
  parameter int CNT_W = 24,
  parameter int TOT_W = 32,
  parameter int IDX_W = $clog2(SLOTS),
  parameter int ACC_W = CNT_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic             ref_was_repl,
  input  logic             ref_will_repl,
  output logic             ann_valid,
  output logic [1:0]       ann_code,
  input  logic [7:0]       threshold,
  input  logic             label_start,
  output logic             label_busy,
  output logic             label_done,
  output logic [SLOTS-1:0] lbl_long,
  output logic [ACC_W-1:0] residual_misses,
  output logic [ACC_W-1:0] prefetch_refs,
  output logic [TOT_W-1:0] tot_nothing,
  output logic [TOT_W-1:0] tot_pretouch,
  output logic [TOT_W-1:0] tot_prefetch,
  output logic [TOT_W-1:0] tot_replace
);

  localparam int PW = CNT_W + 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [TOT_W-1:0] TOT_MAX = '1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [CNT_W-1:0] refc  [SLOTS];
  logic [CNT_W-1:0] missc [SLOTS];
  logic [TOT_W-1:0] tot   [4];
  logic [IDX_W-1:0] ptr;
  logic [7:0]       thr_q;
  logic [1:0]       ann_next;
  logic             accept;

  assign accept   = ref_valid & ~clr;
  assign ann_next = ref_was_repl ? (ref_will_repl ? 2'd2 : 2'd1)
                                 : (ref_will_repl ? 2'd3 : 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        refc[i]  <= '0;
        missc[i] <= '0;
      end
    end else if (clr) begin
      for (int i = 0; i < SLOTS; i++) begin
        refc[i]  <= '0;
        missc[i] <= '0;
      end
    end else if (ref_valid) begin
      if (refc[ref_idx] != CNT_MAX) refc[ref_idx] <= refc[ref_idx] + 1'b1;
      if (ref_was_repl && missc[ref_idx] != CNT_MAX)
        missc[ref_idx] <= missc[ref_idx] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) tot[k] <= '0;
      ann_valid <= 1'b0;
      ann_code  <= 2'd0;
    end else begin
      ann_valid <= accept;
      if (accept) ann_code <= ann_next;
      if (clr) begin
        for (int k = 0; k < 4; k++) tot[k] <= '0;
      end else if (ref_valid && tot[ann_next] != TOT_MAX) begin
        tot[ann_next] <= tot[ann_next] + 1'b1;
      end
    end
  end

  assign tot_nothing  = tot[0];
  assign tot_pretouch = tot[1];
  assign tot_prefetch = tot[2];
  assign tot_replace  = tot[3];

  logic [CNT_W-1:0] s_ref, s_miss;
  logic [PW-1:0]    lhs, rhs;
  logic             is_long;

  assign s_ref   = refc[ptr];
  assign s_miss  = missc[ptr];
  assign lhs     = {s_miss, 8'b0};
  assign rhs     = PW'(thr_q) * PW'(s_ref);
  assign is_long = lhs > rhs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr             <= '0;
      thr_q           <= '0;
      label_busy      <= 1'b0;
      label_done      <= 1'b0;
      lbl_long        <= '0;
      residual_misses <= '0;
      prefetch_refs   <= '0;
    end else if (clr) begin
      ptr             <= '0;
      label_busy      <= 1'b0;
      label_done      <= 1'b0;
      lbl_long        <= '0;
      residual_misses <= '0;
      prefetch_refs   <= '0;
    end else if (!label_busy) begin
      label_done <= 1'b0;
      if (label_start) begin
        label_busy      <= 1'b1;
        ptr             <= '0;
        thr_q           <= threshold;
        residual_misses <= '0;
        prefetch_refs   <= '0;
      end
    end else begin
      lbl_long[ptr] <= is_long;
      if (is_long) prefetch_refs   <= prefetch_refs + ACC_W'(s_ref);
      else         residual_misses <= residual_misses + ACC_W'(s_miss);
      if (ptr == LAST) begin
        label_busy <= 1'b0;
        label_done <= 1'b1;
      end
      ptr <= ptr + 1'b1;
    end
  end

  AST_ANN_PRETOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ann_valid && ann_code == 2'd1) |-> ($past(ref_was_repl) && !$past(ref_will_repl))); // R1
  AST_ANN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ann_valid |-> ($past(ref_valid) && !$past(clr))); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    label_done |-> ($past(label_busy) && !label_busy)); // R5
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (lbl_long == '0 && !label_busy && tot_prefetch == '0 && residual_misses == '0)); // R8
  AST_TOTAL_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (tot_replace >= $past(tot_replace))); // R7

endmodule

// File: tb/tb_miss_profiler.sv
`timescale 1ns/1ps
module tb_miss_profiler;
  localparam int SLOTS = 8;
  localparam int CNT_W = 6;
  localparam int TOT_W = 32;
  localparam int IDX_W = 3;
  localparam int ACC_W = CNT_W + IDX_W;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, clr = 0, ref_valid = 0, ref_was_repl = 0, ref_will_repl = 0;
  logic [IDX_W-1:0] ref_idx = 0;
  logic [7:0] threshold = 0;
  logic label_start = 0;
  logic ann_valid, label_busy, label_done;
  logic [1:0] ann_code;
  logic [SLOTS-1:0] lbl_long;
  logic [ACC_W-1:0] residual_misses, prefetch_refs;
  logic [TOT_W-1:0] tot_nothing, tot_pretouch, tot_prefetch, tot_replace;

  miss_profiler #(.SLOTS(SLOTS), .CNT_W(CNT_W), .TOT_W(TOT_W)) dut (
    .clk, .rst_n, .clr, .ref_valid, .ref_idx, .ref_was_repl, .ref_will_repl,
    .ann_valid, .ann_code, .threshold, .label_start, .label_busy, .label_done,
    .lbl_long, .residual_misses, .prefetch_refs,
    .tot_nothing, .tot_pretouch, .tot_prefetch, .tot_replace);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int mref[SLOTS], mmiss[SLOTS];
  longint mtot[4];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_totals(string req);
    chk(tot_nothing  == mtot[0], req, "tot_nothing",  tot_nothing,  mtot[0]);
    chk(tot_pretouch == mtot[1], req, "tot_pretouch", tot_pretouch, mtot[1]);
    chk(tot_prefetch == mtot[2], req, "tot_prefetch", tot_prefetch, mtot[2]);
    chk(tot_replace  == mtot[3], req, "tot_replace",  tot_replace,  mtot[3]);
  endtask

  task automatic send(int idx, bit w, bit f);
    int exp;
    @(negedge clk);
    ref_valid = 1; ref_idx = IDX_W'(idx); ref_was_repl = w; ref_will_repl = f;
    @(posedge clk); #1;
    ref_valid = 0;
    exp = w ? (f ? 2 : 1) : (f ? 3 : 0);
    chk(ann_valid == 1'b1 && ann_code == 2'(exp), "R1", "ann_code", ann_code, exp);
    if (mref[idx] < CMAX) mref[idx]++;
    if (w && mmiss[idx] < CMAX) mmiss[idx]++;
    mtot[exp]++;
  endtask

  task automatic label(int thr, bit retrig);
    int n;
    longint res, pf;
    bit el;
    @(negedge clk);
    threshold = 8'(thr); label_start = 1;
    @(posedge clk); #1;
    label_start = 0;
    chk(label_busy == 1'b1, "R5", "busy after start", label_busy, 1);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      label_start = (retrig && n == 2);
      if (n == 3) threshold = 8'(255 - thr);
    end while (!label_done && n < 100);
    label_start = 0;
    chk(n == SLOTS, "R5", "done latency", n, SLOTS);
    chk(label_busy == 1'b0, "R5", "busy at done", label_busy, 0);
    res = 0; pf = 0;
    for (int i = 0; i < SLOTS; i++) begin
      el = (longint'(mmiss[i]) * 256) > (longint'(thr) * mref[i]);
      chk(lbl_long[i] == el, "R4", $sformatf("label slot %0d thr %0d", i, thr), lbl_long[i], el);
      if (el) pf += mref[i]; else res += mmiss[i];
    end
    chk(residual_misses == res, "R6", "residual_misses", residual_misses, res);
    chk(prefetch_refs == pf, "R6", "prefetch_refs", prefetch_refs, pf);
    @(posedge clk); #1;
    chk(label_done == 1'b0, "R5", "done one cycle", label_done, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin mref[i] = 0; mmiss[i] = 0; end
    for (int k = 0; k < 4; k++) mtot[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(ann_valid == 0 && label_busy == 0 && label_done == 0, "R8", "reset flags", ann_valid, 0);
    chk(lbl_long == 0 && residual_misses == 0 && prefetch_refs == 0, "R8", "reset labels", lbl_long, 0);
    check_totals("R7");

    // R1 R2: every flag pair into every slot, varied miss density
    for (int s = 0; s < SLOTS; s++)
      for (int k = 0; k < 2 * s + 4; k++)
        send(s, ((k * 5 + s) % 3) == 0 || s == 5, k[0]);
    @(posedge clk); #1;
    chk(ann_valid == 1'b0, "R1", "ann_valid idle", ann_valid, 0);
    check_totals("R7");

    // R2 R4 R6: threshold sweep
    label(0, 0);
    label(64, 0);
    label(128, 0);
    label(200, 0);
    label(255, 1);

    // R3: drive past counter capacity in two slots
    for (int k = 0; k < CMAX + 8; k++) send(7, 1, 1);
    for (int k = 0; k < CMAX + 8; k++) send(6, 0, 0);
    chk(mref[7] == CMAX && mmiss[7] == CMAX, "R3", "model saturated", mref[7], CMAX);
    label(255, 0);
    label(100, 0);
    check_totals("R7");

    // R8: clear with a simultaneous reference
    @(negedge clk);
    clr = 1; ref_valid = 1; ref_idx = 3; ref_was_repl = 1; ref_will_repl = 0;
    @(posedge clk); #1;
    clr = 0; ref_valid = 0;
    for (int i = 0; i < SLOTS; i++) begin mref[i] = 0; mmiss[i] = 0; end
    for (int k = 0; k < 4; k++) mtot[k] = 0;
    chk(ann_valid == 1'b0, "R8", "ann_valid after clr", ann_valid, 0);
    chk(lbl_long == 0, "R8", "labels cleared", lbl_long, 0);
    chk(residual_misses == 0 && prefetch_refs == 0, "R8", "sums cleared", residual_misses, 0);
    check_totals("R8");
    label(0, 0);
    send(3, 1, 0);
    label(0, 0);

    // R8: clear aborts a running pass
    @(negedge clk); threshold = 0; label_start = 1;
    @(posedge clk); #1; label_start = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); clr = 1;
    @(posedge clk); #1; clr = 0;
    chk(label_busy == 1'b0, "R8", "pass aborted", label_busy, 0);
    repeat (SLOTS) begin
      @(posedge clk); #1;
      chk(label_done == 1'b0, "R8", "no done after abort", label_done, 0);
    end
    chk(lbl_long == 0, "R8", "labels after abort", lbl_long, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule